// File: doc/BRIEF.md
# Ordered Key-Load Sequence Checker

This block sits beside a bank of 32-bit key word registers and polices how software fills them. Every key word write is stored at its index. In parallel, a small tracker checks that the words arrive as one unbroken run, either strictly upward from the lowest index or strictly downward from the highest. The length of the run is four words for a 128-bit key and eight words for a 256-bit key. A run that completes without fault raises a key-valid status. Any write that breaks the run raises a sticky key-error flag instead, and that flag keeps key-valid low until software clears it.

Software clears the error by writing one to a separate clear bit, which reaches this block as a single-cycle strobe. An interrupt line follows the error flag, gated by an enable input. If the key size select changes while a load is half done, the load is dropped without any error. The cipher datapath that uses the stored key is not part of this block.

Top module: `key_load_checker`

## Requirements
- R1: While reset is active, and after it, all key words read zero, key_valid_o is 0, key_err_o is 0, key_irq_o is 0, and the tracker is idle, so the next write is judged as a first write.
- R2: With key_size_i = 0, writes to indices 0, 1, 2, 3 in that order raise key_valid_o in the cycle after the write of index 3. key_valid_o then holds while no further write occurs.
- R3: With key_size_i = 0, writes to indices 3, 2, 1, 0 in that order raise key_valid_o in the cycle after the write of index 0.
- R4: With key_size_i = 1, writes to indices 0 through 7 ascending, or 7 through 0 descending, raise key_valid_o in the cycle after the eighth write.
- R5: key_err_o becomes 1 in the cycle after any of these writes: a first write to an index other than 0 or the highest index of the current size; a later write to an index other than the next one in the chosen direction; or a write to an index above 3 while key_size_i = 0. After such an error the tracker returns to idle.
- R6: key_err_o stays at 1 until a cycle with err_clr_i = 1, and is 0 in the following cycle. If an error write and err_clr_i arrive in the same cycle, the flag stays set.
- R7: While key_err_o is 1, key_valid_o stays 0, even when a complete legal sequence is written. After the flag is cleared, a new legal sequence raises key_valid_o again.
- R8: key_irq_o is 1 exactly when key_err_o is 1 and err_ie_i is 1.
- R9: Any key word write while key_valid_o is 1 drives key_valid_o to 0 in the next cycle, and that write begins a new sequence.
- R10: A change of key_size_i during a partial load returns the tracker to idle, and key_err_o stays 0. Continuing the old run afterwards counts as an error, while a fresh first write with the new size starts a new load.
- R11: Every key word write stores wr_data_i at bits [32*idx +: 32] of key_o, visible in the next cycle, whether or not the write breaks the order. The other words are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Key word write strobe |
| wr_idx_i | input | 3 | Index of the key word being written |
| wr_data_i | input | 32 | Key word write data |
| key_size_i | input | 1 | Key size select: 0 = 128-bit (4 words), 1 = 256-bit (8 words) |
| err_clr_i | input | 1 | Error clear strobe (software wrote 1 to the clear bit) |
| err_ie_i | input | 1 | Key-error interrupt enable |
| key_o | output | 256 | Stored key words, word n at bits [32*n +: 32] |
| key_valid_o | output | 1 | A complete, legally ordered key is loaded |
| key_err_o | output | 1 | Sticky key-error flag |
| key_irq_o | output | 1 | Key-error interrupt |

## Verification
If the tracker holds the wrong direction or the wrong next index, the fault shows on key_err_o one cycle after the next write. It shows on key_valid_o no later than the cycle after the final write of the run, when key-valid fails to rise or rises early. A failure to drop a sequence on a key size change shows in the first write after the change: that write either raises a false error or completes a run of the wrong length. A lost or stuck error flag shows directly on key_err_o and key_irq_o, and it shows as key_valid_o rising while the flag should still block it.

// File: rtl/key_load_pkg.sv
package key_load_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_ASC  = 2'd1,
    TRK_DESC = 2'd2
  } trk_state_e;
endpackage

// File: rtl/key_word_bank.sv
module key_word_bank #(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 8,
  localparam int IDX_W    = $clog2(MAX_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [WORD_W-1:0]           wr_data_i,
  output logic [MAX_WORDS*WORD_W-1:0] key_o
);
  logic [WORD_W-1:0] words_q [MAX_WORDS];

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_q[w] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(w))) begin
        words_q[w] <= wr_data_i;
      end
    end
    assign key_o[w*WORD_W +: WORD_W] = words_q[w];
  end
endmodule

// File: rtl/key_order_tracker.sv
module key_order_tracker
  import key_load_pkg::*;
#(
  parameter int MAX_WORDS   = 8,
  parameter int SHORT_WORDS = 4,
  localparam int IDX_W      = $clog2(MAX_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             key_size_i,
  output logic             order_err_o,
  output logic             seq_done_o
);
  trk_state_e       state_q, state_d, cur_state;
  logic [IDX_W-1:0] next_q, next_d;
  logic             size_q, size_d;
  logic [IDX_W-1:0] last_idx;
  logic             size_changed;

  assign last_idx     = key_size_i ? IDX_W'(MAX_WORDS - 1) : IDX_W'(SHORT_WORDS - 1);
  // a size change drops a partial load silently
  assign size_changed = (state_q != TRK_IDLE) && (key_size_i != size_q);
  assign cur_state    = size_changed ? TRK_IDLE : state_q;

  always_comb begin
    state_d     = cur_state;
    next_d      = next_q;
    size_d      = size_q;
    order_err_o = 1'b0;
    seq_done_o  = 1'b0;
    if (wr_en_i) begin
      unique case (cur_state)
        TRK_IDLE: begin
          size_d = key_size_i;
          if (wr_idx_i == '0) begin
            state_d = TRK_ASC;
            next_d  = IDX_W'(1);
          end else if (wr_idx_i == last_idx) begin
            state_d = TRK_DESC;
            next_d  = last_idx - IDX_W'(1);
          end else begin
            order_err_o = 1'b1;
          end
        end
        TRK_ASC: begin
          if (wr_idx_i != next_q) begin
            order_err_o = 1'b1;
            state_d     = TRK_IDLE;
          end else if (wr_idx_i == last_idx) begin
            seq_done_o = 1'b1;
            state_d    = TRK_IDLE;
          end else begin
            next_d = next_q + IDX_W'(1);
          end
        end
        TRK_DESC: begin
          if (wr_idx_i != next_q) begin
            order_err_o = 1'b1;
            state_d     = TRK_IDLE;
          end else if (wr_idx_i == '0) begin
            seq_done_o = 1'b1;
            state_d    = TRK_IDLE;
          end else begin
            next_d = next_q - IDX_W'(1);
          end
        end
        default: begin
          state_d = TRK_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_IDLE;
      next_q  <= '0;
      size_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      next_q  <= next_d;
      size_q  <= size_d;
    end
  end
endmodule

// File: rtl/key_status.sv
module key_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic order_err_i,
  input  logic seq_done_i,
  input  logic err_clr_i,
  input  logic err_ie_i,
  output logic key_valid_o,
  output logic key_err_o,
  output logic key_irq_o
);
  logic valid_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (order_err_i) begin
      err_q <= 1'b1;  // set beats clear
    end else if (err_clr_i) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else if (wr_en_i) begin
      valid_q <= seq_done_i && !err_q;
    end
  end

  assign key_valid_o = valid_q;
  assign key_err_o   = err_q;
  assign key_irq_o   = err_q & err_ie_i;
endmodule

// File: rtl/key_load_checker.sv
module key_load_checker #(
  parameter int WORD_W      = 32,
  parameter int MAX_WORDS   = 8,
  parameter int SHORT_WORDS = 4,
  localparam int IDX_W      = $clog2(MAX_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [WORD_W-1:0]           wr_data_i,
  input  logic                        key_size_i,
  input  logic                        err_clr_i,
  input  logic                        err_ie_i,
  output logic [MAX_WORDS*WORD_W-1:0] key_o,
  output logic                        key_valid_o,
  output logic                        key_err_o,
  output logic                        key_irq_o
);
  logic order_err, seq_done;

  key_word_bank #(
    .WORD_W   (WORD_W),
    .MAX_WORDS(MAX_WORDS)
  ) bank_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_data_i(wr_data_i),
    .key_o    (key_o)
  );

  key_order_tracker #(
    .MAX_WORDS  (MAX_WORDS),
    .SHORT_WORDS(SHORT_WORDS)
  ) trk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .key_size_i (key_size_i),
    .order_err_o(order_err),
    .seq_done_o (seq_done)
  );

  key_status stat_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .order_err_i(order_err),
    .seq_done_i (seq_done),
    .err_clr_i  (err_clr_i),
    .err_ie_i   (err_ie_i),
    .key_valid_o(key_valid_o),
    .key_err_o  (key_err_o),
    .key_irq_o  (key_irq_o)
  );
endmodule

// File: rtl/key_load_checker_chk.sv
module key_load_checker_chk #(
  parameter int WORD_W      = 32,
  parameter int MAX_WORDS   = 8,
  localparam int IDX_W      = $clog2(MAX_WORDS)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wr_en_i,
  input logic [IDX_W-1:0]            wr_idx_i,
  input logic [WORD_W-1:0]           wr_data_i,
  input logic                        err_clr_i,
  input logic                        err_ie_i,
  input logic [MAX_WORDS*WORD_W-1:0] key_o,
  input logic                        key_valid_o,
  input logic                        key_err_o,
  input logic                        key_irq_o
);
  logic              last_wr_q;
  logic [IDX_W-1:0]  last_idx_q;
  logic [WORD_W-1:0] last_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_wr_q   <= 1'b0;
      last_idx_q  <= '0;
      last_data_q <= '0;
    end else begin
      last_wr_q   <= wr_en_i;
      last_idx_q  <= wr_idx_i;
      last_data_q <= wr_data_i;
    end
  end

  // R11
  word_stored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_wr_q |-> key_o[int'(last_idx_q)*WORD_W +: WORD_W] == last_data_q);

  // R7
  err_blocks_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_err_o |-> !key_valid_o);

  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_err_o && !err_clr_i |=> key_err_o);

  // R6
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !wr_en_i |=> !key_err_o);

  // R5
  err_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_err_o) |-> $past(wr_en_i));

  // R9
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && key_valid_o |=> !key_valid_o);

  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_valid_o) |-> $past(wr_en_i) && !$past(key_err_o));

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_irq_o |-> key_err_o && err_ie_i);
endmodule

bind key_load_checker key_load_checker_chk #(
  .WORD_W   (WORD_W),
  .MAX_WORDS(MAX_WORDS)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_data_i  (wr_data_i),
  .err_clr_i  (err_clr_i),
  .err_ie_i   (err_ie_i),
  .key_o      (key_o),
  .key_valid_o(key_valid_o),
  .key_err_o  (key_err_o),
  .key_irq_o  (key_irq_o)
);

// File: tb/key_load_checker_tb_top.sv
module key_load_checker_tb_top;
  localparam int WORD_W    = 32;
  localparam int MAX_WORDS = 8;
  localparam int IDX_W     = 3;
  localparam int NV        = 62;

  logic                        clk, rst_n;
  logic                        wr_en, key_size, err_clr, err_ie;
  logic [IDX_W-1:0]            wr_idx;
  logic [WORD_W-1:0]           wr_data;
  logic [MAX_WORDS*WORD_W-1:0] key;
  logic                        key_valid, key_err, key_irq;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  key_load_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .key_size_i(key_size), .err_clr_i(err_clr),
    .err_ie_i(err_ie), .key_o(key), .key_valid_o(key_valid),
    .key_err_o(key_err), .key_irq_o(key_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {we, idx[3], ks, clr, ie, exp_valid, exp_err, exp_irq, req[4]}
  function automatic logic [13:0] mk(int we, int idx, int ks, int clr, int ie,
                                     int ev, int ee, int ei, int req);
    return {1'(we), 3'(idx), 1'(ks), 1'(clr), 1'(ie), 1'(ev), 1'(ee), 1'(ei), 4'(req)};
  endfunction

  localparam logic [13:0] VECS [NV] = '{
    mk(1,0,0,0,0,0,0,0,2), mk(1,1,0,0,0,0,0,0,2), mk(1,2,0,0,0,0,0,0,2),
    mk(1,3,0,0,0,1,0,0,2),                         // R2 valid after word 3
    mk(0,0,0,0,0,1,0,0,2),                         // R2 holds
    mk(1,3,0,0,0,0,0,0,9),                         // R9 new write drops valid
    mk(1,2,0,0,0,0,0,0,3), mk(1,1,0,0,0,0,0,0,3),
    mk(1,0,0,0,0,1,0,0,3),                         // R3 descending done
    mk(1,1,0,0,0,0,1,0,5),                         // R5 bad first index
    mk(0,0,0,0,1,0,1,1,8),                         // R8 irq with enable
    mk(1,0,0,0,1,0,1,1,7), mk(1,1,0,0,1,0,1,1,7), mk(1,2,0,0,1,0,1,1,7),
    mk(1,3,0,0,1,0,1,1,7),                         // R7 valid blocked
    mk(0,0,0,1,1,0,0,0,6),                         // R6 clear
    mk(1,0,0,0,0,0,0,0,7), mk(1,1,0,0,0,0,0,0,7), mk(1,2,0,0,0,0,0,0,7),
    mk(1,3,0,0,0,1,0,0,7),                         // R7 recovers
    mk(1,0,1,0,0,0,0,0,4), mk(1,1,1,0,0,0,0,0,4), mk(1,2,1,0,0,0,0,0,4),
    mk(1,3,1,0,0,0,0,0,4), mk(1,4,1,0,0,0,0,0,4), mk(1,5,1,0,0,0,0,0,4),
    mk(1,6,1,0,0,0,0,0,4), mk(1,7,1,0,0,1,0,0,4), // R4 ascending 8
    mk(1,7,1,0,0,0,0,0,4), mk(1,6,1,0,0,0,0,0,4), mk(1,5,1,0,0,0,0,0,4),
    mk(1,4,1,0,0,0,0,0,4), mk(1,3,1,0,0,0,0,0,4), mk(1,2,1,0,0,0,0,0,4),
    mk(1,1,1,0,0,0,0,0,4), mk(1,0,1,0,0,1,0,0,4), // R4 descending 8
    mk(1,0,1,0,0,0,0,0,5), mk(1,2,1,0,0,0,1,0,5), // R5 skipped index
    mk(1,5,1,1,0,0,1,0,6),                         // R6 set beats clear
    mk(0,0,1,1,0,0,0,0,6),
    mk(1,0,0,0,0,0,0,0,10), mk(1,1,0,0,0,0,0,0,10),
    mk(0,0,1,0,0,0,0,0,10),                        // R10 size change, no error
    mk(1,2,1,0,0,0,1,0,10),                        // R10 old run aborted
    mk(0,0,1,1,0,0,0,0,6),
    mk(1,0,0,0,0,0,0,0,10), mk(1,1,0,0,0,0,0,0,10),
    mk(1,0,1,0,0,0,0,0,10), mk(1,1,1,0,0,0,0,0,10), mk(1,2,1,0,0,0,0,0,10),
    mk(1,3,1,0,0,0,0,0,10), mk(1,4,1,0,0,0,0,0,10), mk(1,5,1,0,0,0,0,0,10),
    mk(1,6,1,0,0,0,0,0,10), mk(1,7,1,0,0,1,0,0,10),// R10 fresh load
    mk(1,0,0,0,0,0,0,0,5), mk(1,1,0,0,0,0,0,0,5), mk(1,2,0,0,0,0,0,0,5),
    mk(1,4,0,0,0,0,1,0,5),                         // R5 index above 3
    mk(0,0,0,1,0,0,0,0,6),
    mk(1,3,0,0,0,0,0,0,5), mk(1,1,0,0,0,0,1,0,5)  // R5 wrong descent
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(input string req, input bit ev, input bit ee, input bit ei);
    check(key_valid === ev, req, "key_valid", 32'(key_valid), 32'(ev));
    check(key_err === ee, req, "key_err", 32'(key_err), 32'(ee));
    check(key_irq === ei, req, "key_irq", 32'(key_irq), 32'(ei));
  endtask

  task automatic do_write(input int idx, input bit ks, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); key_size = ks; wr_data = d;
    err_clr = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    key_size = 1'b0; err_clr = 1'b0; err_ie = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(key === '0, "R1", "key during reset", key[31:0], 32'h0);
    check_flags("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1; err_ie = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [13:0]       v;
      logic [WORD_W-1:0] d;
      string             rq;
      v  = VECS[i];
      d  = {8'hC5, 8'(i), 13'h0, v[12:10]};
      rq = $sformatf("R%0d", v[3:0]);
      @(negedge clk);
      wr_en = v[13]; wr_idx = v[12:10]; key_size = v[9];
      err_clr = v[8]; err_ie = v[7]; wr_data = d;
      @(posedge clk); #1;
      check_flags($sformatf("%s vec%0d", rq, i), v[6], v[5], v[4]);
      if (v[13]) begin
        // R11 each write lands at its index
        check(key[int'(v[12:10])*WORD_W +: WORD_W] === d, "R11", "stored word",
              key[int'(v[12:10])*WORD_W +: WORD_W], d);
      end
    end

    // R1 reset mid-run clears state; flag was set by last vector
    @(negedge clk); wr_en = 1'b0; err_clr = 1'b0; err_ie = 1'b1;
    rst_n = 1'b0;
    #1;
    check(key === '0, "R1", "key after reset", key[63:32], 32'h0);
    check_flags("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1; err_ie = 1'b0;

    // R1 tracker idle after reset: index 1 as first write is an error
    do_write(1, 1'b0, 32'h1111_2222);
    check_flags("R1", 1'b0, 1'b1, 1'b0);

    // R11 a single write touches only its word
    do_write(5, 1'b1, 32'hDEAD_BEEF);
    check(key[5*WORD_W +: WORD_W] === 32'hDEAD_BEEF, "R11", "word5",
          key[5*WORD_W +: WORD_W], 32'hDEAD_BEEF);
    check(key[1*WORD_W +: WORD_W] === 32'h1111_2222, "R11", "word1 kept",
          key[1*WORD_W +: WORD_W], 32'h1111_2222);
    check(key[0 +: WORD_W] === 32'h0, "R11", "word0 untouched",
          key[0 +: WORD_W], 32'h0);

    // R6 flag survives idle cycles without clear
    repeat (3) @(posedge clk);
    #1;
    check(key_err === 1'b1, "R6", "sticky", 32'(key_err), 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule